// File: doc/BRIEF.md
# Continuous-Flow Scan Stimulus Decompressor

This block turns a handful of tester input channels into a wide set of scan-chain load streams, one bit per chain on every shift cycle. It is built around a 32-stage ring-form linear register. Each channel bit is XORed into its own register stage on every advancing cycle, so new variables arrive throughout the whole load and not only at seed time. A shallow XOR phase shifter then spreads the register state across the chain outputs.

The feedback realises the characteristic polynomial x^32 + x^18 + x^14 + x^9 + 1. Its three feedback connections are spread around the ring. As a result, every register stage is fed through at most one 2-input XOR, and no stage drives more than two loads inside the ring. Each chain output is the XOR of exactly three stages.

After reset, a short initialization phase fills the register from the channels. A valid flag rises only once that phase is over. A burn-in mode lets the register free-run on every clock from a fixed nonzero constant, whatever the channel pins and shift enable carry.

Top module: `scan_stim_decomp`

## Requirements
- R1: A synchronous active-high `rst` clears all 32 register stages to zero, which drives every `chain_out` bit to 0, and it drops `scan_valid` to 0.
- R2: The register advances on a clock edge only when `shift_en` or `burn_in` is 1. When both are 0, the register, `chain_out` and `scan_valid` hold their values, and `chan_in` has no effect.
- R3: On an advance, the stage update is as follows. Stage 0 takes stage 31. Stage 9 takes stage 8 XOR stage 31. Stage 11 takes stage 10 XOR stage 28. Stage 12 takes stage 11 XOR stage 25. Every other stage k takes stage k-1, with injection added as described in R4.
- R4: With the defaults (NUM_CHAN=8, INJ_FIRST=2), channel i is XORed into the input of stage 2+4*i. These are stages 2, 6, 10, 14, 18, 22, 26 and 30, and the injection happens on every advance.
- R5: Chain output j is stage j XOR stage (j+11) mod 32 XOR stage (j+23) mod 32. It is combinational from the register.
- R6: `scan_valid` stays 0 until INIT_CYCLES advances (default 4) have happened since reset. It goes to 1 on the edge of the last of those advances and stays 1 until the next reset.
- R7: While `burn_in` is 1, the register advances on every clock whatever `shift_en` is. It injects the constant BURN_VAL (default 8'hA5, bit i to channel i) in place of `chan_in`, which is ignored.
- R8: An all-zero register that advances with all-zero injected bits stays all-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst | input | 1 | Synchronous reset, active high |
| shift_en | input | 1 | Advance the register this cycle |
| burn_in | input | 1 | Free-run from the constant injection pattern |
| chan_in | input | NUM_CHAN | Tester channel bits injected per advance |
| chain_out | output | NUM_CHAINS | One load bit per scan chain |
| scan_valid | output | 1 | Initialization phase complete |

## Verification
The main stimulus is random channel data mixed with random shift-enable gaps. Per-cycle comparison of every chain output against an independent model catches wrong feedback taps, wrong injection stages and wrong phase-shifter taps. The gaps separate a correct hold from a stray advance. A single injected one followed by zeros isolates the feedback ring from injection, so a misplaced tap shows up after a few dozen cycles. All-zero input shows the zero state locking. Burn-in runs with random channel pins and shift enable held low, which shows that the constant replaces the pins and that the clock alone advances the register.

// File: rtl/scan_stim_decomp.sv
module scan_stim_decomp #(
  parameter int unsigned NUM_CHAN    = 8,
  parameter int unsigned NUM_CHAINS  = 16,
  parameter int unsigned INIT_CYCLES = 4,
  parameter int unsigned INJ_FIRST   = 2,
  parameter int unsigned BURN_VAL    = 'hA5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  shift_en,
  input  logic                  burn_in,
  input  logic [NUM_CHAN-1:0]   chan_in,
  output logic [NUM_CHAINS-1:0] chain_out,
  output logic                  scan_valid
);

  localparam int unsigned RING    = 32;
  localparam int unsigned SPACING = RING / NUM_CHAN;
  localparam int unsigned CNT_W   = $clog2(INIT_CYCLES + 1) < 1 ? 1 : $clog2(INIT_CYCLES + 1);
  localparam logic [NUM_CHAN-1:0] BURN_BITS = NUM_CHAN'(BURN_VAL);
  localparam logic [CNT_W-1:0]    CNT_DONE  = CNT_W'(INIT_CYCLES);

  logic [RING-1:0]     ring, nxt;
  logic [NUM_CHAN-1:0] inj;
  logic [CNT_W-1:0]    cnt;
  logic                adv;

  initial begin
    assert_param_R4: assert (RING % NUM_CHAN == 0 && NUM_CHAINS <= RING);
    for (int i = 0; i < NUM_CHAN; i++) begin
      int s;
      s = int'(INJ_FIRST + i * SPACING) % RING;
      assert_inj_stage_R4: assert (s != 0 && s != 9 && s != 11 && s != 12);
    end
  end

  assign adv = shift_en | burn_in;
  assign inj = burn_in ? BURN_BITS : chan_in;

  always_comb begin
    nxt[0] = ring[RING-1];
    for (int k = 1; k < RING; k++) nxt[k] = ring[k-1];
    nxt[9]  = nxt[9]  ^ ring[31];
    nxt[11] = nxt[11] ^ ring[28];
    nxt[12] = nxt[12] ^ ring[25];
    for (int i = 0; i < NUM_CHAN; i++)
      nxt[(INJ_FIRST + i * SPACING) % RING] = nxt[(INJ_FIRST + i * SPACING) % RING] ^ inj[i];
  end

  always_ff @(posedge clk) begin
    if (rst)      ring <= '0;
    else if (adv) ring <= nxt;
  end

  always_ff @(posedge clk) begin
    if (rst)                         cnt <= '0;
    else if (adv && cnt != CNT_DONE) cnt <= cnt + 1'b1;
  end

  assign scan_valid = (cnt == CNT_DONE);

  genvar j;
  generate
    for (j = 0; j < NUM_CHAINS; j++) begin : g_ps
      assign chain_out[j] = ring[j % RING] ^ ring[(j + 11) % RING] ^ ring[(j + 23) % RING];
    end
  endgenerate

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (ring == '0 && !scan_valid));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(ring));

  assert_ring_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    adv |=> ring[0] == $past(ring[31]));

  assert_valid_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    scan_valid |=> scan_valid);

  assert_valid_rise_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(scan_valid) |-> $past(adv));

  assert_burn_kick_R7: assert property (@(posedge clk) disable iff (rst)
    (burn_in && ring == '0 && BURN_BITS != '0) |=> ring != '0);

  assert_zero_lock_R8: assert property (@(posedge clk) disable iff (rst)
    (ring == '0 && inj == '0) |=> ring == '0);

endmodule

// File: tb/scan_stim_decomp_tb.sv
`timescale 1ns/1ps
module scan_stim_decomp_tb_top;
  localparam int NCH = 8;
  localparam int NCO = 16;
  localparam int INIT = 4;
  localparam logic [NCH-1:0] BURN = 8'hA5;

  logic clk = 0, rst = 1, shift_en = 0, burn_in = 0;
  logic [NCH-1:0] chan_in = '0;
  logic [NCO-1:0] chain_out;
  logic scan_valid;

  int checks = 0, errors = 0;
  logic [31:0] m_ring;
  int m_cnt;

  always #4 clk = ~clk;

  scan_stim_decomp dut_i (.clk(clk), .rst(rst), .shift_en(shift_en), .burn_in(burn_in),
                          .chan_in(chan_in), .chain_out(chain_out), .scan_valid(scan_valid));

  function automatic logic [31:0] step_ring(logic [31:0] s, logic [NCH-1:0] c);
    logic [31:0] n;
    n[0] = s[31];
    for (int k = 1; k < 32; k++) n[k] = s[k-1];
    n[9] ^= s[31];
    n[11] ^= s[28];
    n[12] ^= s[25];
    for (int i = 0; i < NCH; i++) n[2 + 4*i] ^= c[i];
    return n;
  endfunction

  function automatic logic [NCO-1:0] shifter(logic [31:0] s);
    logic [NCO-1:0] o;
    for (int j = 0; j < NCO; j++) o[j] = s[j] ^ s[(j+11)%32] ^ s[(j+23)%32];
    return o;
  endfunction

  task automatic chk(string tag, logic [NCO-1:0] got, logic [NCO-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic cyc(logic r, logic se, logic bi, logic [NCH-1:0] ch, string tag);
    rst = r; shift_en = se; burn_in = bi; chan_in = ch;
    if (r) begin m_ring = '0; m_cnt = 0; end
    else if (se || bi) begin
      m_ring = step_ring(m_ring, bi ? BURN : ch);
      if (m_cnt < INIT) m_cnt++;
    end
    @(negedge clk);
    chk({tag, " chain_out"}, chain_out, shifter(m_ring));
    chk({tag, " scan_valid"}, NCO'(scan_valid), NCO'(m_cnt == INIT));
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    m_ring = '0; m_cnt = 0;
    @(negedge clk);
    cyc(1, 0, 0, '1, "R1");
    cyc(1, 1, 0, '1, "R1");
    // zero input: lock at zero, valid after INIT advances
    for (int i = 0; i < 6; i++) cyc(0, 1, 0, '0, (i < 3) ? "R8" : "R6");
    // random load with gaps
    for (int i = 0; i < 400; i++) begin
      logic se;
      se = ($urandom % 10) < 7;
      cyc(0, se, 0, NCH'($urandom), se ? "R4" : "R2");
    end
    // single injected one: feedback ring alone
    cyc(1, 0, 0, '0, "R1");
    cyc(0, 1, 0, 8'h01, "R3");
    for (int i = 0; i < 80; i++) cyc(0, 1, 0, '0, "R3");
    cyc(0, 0, 0, 8'hFF, "R2");
    cyc(0, 0, 0, 8'h3C, "R2");
    // burn-in with random pins and shift enable low
    cyc(1, 0, 0, '0, "R1");
    for (int i = 0; i < 60; i++) cyc(0, 0, 1, NCH'($urandom), "R7");
    for (int i = 0; i < 20; i++) cyc(0, i[0], 1, NCH'($urandom), "R7");
    // chain output spread on a long random run
    for (int i = 0; i < 200; i++) cyc(0, 1, 0, NCH'($urandom), "R5");
    // mid-run reset
    cyc(1, 1, 0, '1, "R1");
    cyc(0, 0, 0, '1, "R6");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule